// File: doc/BRIEF.md
# Dual-Clock Parallel-Load Serial Shifter

This block is a shift register of eight stages, run on a system clock, that behaves like a discrete parallel-in, serial-out shifter. Its eight stages can be filled from a parallel word or advanced one place with a new serial bit entering at the front. The block drives the value of the last stage and its inverse. A parallel-to-serial bridge or a scan-style reader uses it to turn a wide word into a bit stream under the control of slow external strobes.

The block has two external advance inputs, and they are interchangeable. Both are sampled into the system clock domain and combined by OR. The register advances on the system cycle in which that OR goes from 0 to 1. Either input can therefore serve as an active-high inhibit for the other. A mode input chooses between two behaviours. When it is low, the parallel word is loaded continuously, and this load overrides any advance. When it is high, the register shifts.

Top module: `dcs_shifter`

## Requirements
- R1: A synchronous active-low reset clears every stage and the stored combined-advance level. While reset is held and right after it, `tail_o` is 0 and `tail_n_o` is 1.
- R2: While `mode_i` is low, all stages follow `word_i` every cycle, whatever the advance and serial inputs do. Bit 0 of `word_i` goes to the first stage and bit 7 to the last, so `word_i[7]` appears on `tail_o` while loading.
- R3: While `mode_i` is high, each advance moves every stage one place toward the last stage, and `ser_i` enters the first stage. After a load, successive advances therefore present `word_i[6]`, `word_i[5]` and so on, down to `word_i[0]`, followed by the serial bits.
- R4: A rising edge on either `adv_a_i` or `adv_b_i` advances the register when the other input is low.
- R5: While one advance input is high, a rising edge on the other one does not change the register.
- R6: When no rising edge of the combined advance occurs and `mode_i` is high, the register keeps its contents. This includes the falling edges of the advance inputs and changes on `ser_i`.
- R7: Raising the inhibit input while the other advance input is low counts as an advance and causes one extra shift.
- R8: When `mode_i` goes low in the same cycle that an advance edge arrives, the load wins and no shift is applied.
- R9: `tail_n_o` is always the logical inverse of `tail_o`.
- R10: A change on `adv_a_i`, `adv_b_i`, `mode_i` or `ser_i` takes effect on the outputs at the third rising system-clock edge after it is applied, because of two synchronizer stages and one stage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| adv_a_i | input | 1 | External advance / inhibit input A (asynchronous) |
| adv_b_i | input | 1 | External advance / inhibit input B (asynchronous) |
| mode_i | input | 1 | Low: parallel load; high: serial shift (asynchronous) |
| ser_i | input | 1 | Serial bit entering the first stage (asynchronous) |
| word_i | input | STAGES | Parallel word, bit 0 to the first stage |
| tail_o | output | 1 | Value of the last stage |
| tail_n_o | output | 1 | Inverse of the last stage |

## Verification
The hardest situations to produce from the ports are the ones where several events coincide within one synchronizer delay. One is a load that begins in the same cycle as an advance edge. The other is a rise on one advance input while the other is already high. The bench drives those input changes on the same falling edge, so they reach the register in the same system cycle, and it probes the output exactly two and three cycles later to pin down the latency. Between the directed cases, a seeded random walk changes one input at a time. After each change the outputs are compared with a level-based model of load, shift and inhibit.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } stage_op_e;

    // Index of each synchronized control bit inside the sampled vector.
    localparam int unsigned IDX_ADV_A = 0;
    localparam int unsigned IDX_ADV_B = 1;
    localparam int unsigned IDX_MODE  = 2;
    localparam int unsigned IDX_SER   = 3;
    localparam int unsigned CTRL_W    = 4;

endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
    parameter int unsigned         WIDTH     = 4,
    parameter int unsigned         DEPTH     = 2,
    parameter logic [WIDTH-1:0]    RESET_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0][WIDTH-1:0] chain_d;
    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    // First flop takes the raw input, each later flop takes its neighbour.
    assign chain_d[0] = d_i;
    for (genvar s = 1; s < DEPTH; s++) begin : g_chain
        assign chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < DEPTH; s++) begin
                chain_q[s] <= RESET_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/dcs_edge.sv
module dcs_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic a_i,
    input  logic b_i,
    output logic adv_o
);

    typedef struct packed {
        logic level;
    } edge_state_t;

    edge_state_t st_d;
    edge_state_t st_q;
    logic        comb_lvl;

    always_comb begin
        comb_lvl = a_i | b_i;
        st_d.level = comb_lvl;
        adv_o = comb_lvl & ~st_q.level;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: an input held high keeps any edge on the other input from advancing.
    assert_inhibit_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_i && $past(a_i)) |-> !adv_o);
    assert_inhibit_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (b_i && $past(b_i)) |-> !adv_o);

    // R4: a lone rise on either input gives an advance.
    assert_rise_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(a_i) && !b_i && !$past(b_i)) |-> adv_o);
    assert_rise_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(b_i) && !a_i && !$past(a_i)) |-> adv_o);

endmodule

// File: rtl/dcs_stages.sv
module dcs_stages
    import dcs_pkg::*;
#(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  stage_op_e         op_i,
    input  logic [STAGES-1:0] word_i,
    input  logic              ser_i,
    output logic [STAGES-1:0] stage_o
);

    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    always_comb begin
        stage_d = stage_q;
        unique case (op_i)
            OP_LOAD:  stage_d = word_i;
            OP_SHIFT: stage_d = {stage_q[TOP-1:0], ser_i};
            default:  stage_d = stage_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign stage_o = stage_q;

    // R1: reset leaves every stage at zero.
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (stage_q == '0));

    // R6: without a shift or a load the contents stay put.
    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_HOLD) |=> $stable(stage_q));

    // R3: a shift moves the stages toward the end and takes the serial bit.
    assert_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_SHIFT) |=>
        (stage_q[0] == $past(ser_i)) && (stage_q[TOP:1] == $past(stage_q[TOP-1:0])));

endmodule

// File: rtl/dcs_shifter.sv
module dcs_shifter
    import dcs_pkg::*;
#(
    parameter int unsigned STAGES     = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              adv_a_i,
    input  logic              adv_b_i,
    input  logic              mode_i,
    input  logic              ser_i,
    input  logic [STAGES-1:0] word_i,
    output logic              tail_o,
    output logic              tail_n_o
);

    localparam int unsigned     TOP      = STAGES - 1;
    // Mode resets to 1 so the block comes out of reset in shift mode.
    localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << IDX_MODE;

    logic [CTRL_W-1:0] ctrl_raw;
    logic [CTRL_W-1:0] ctrl_s;
    logic              adv;
    stage_op_e         op;
    logic [STAGES-1:0] stages;

    assign ctrl_raw[IDX_ADV_A] = adv_a_i;
    assign ctrl_raw[IDX_ADV_B] = adv_b_i;
    assign ctrl_raw[IDX_MODE]  = mode_i;
    assign ctrl_raw[IDX_SER]   = ser_i;

    dcs_sync #(
        .WIDTH     (CTRL_W),
        .DEPTH     (SYNC_DEPTH),
        .RESET_VAL (CTRL_RST)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (ctrl_raw),
        .q_o    (ctrl_s)
    );

    dcs_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .a_i    (ctrl_s[IDX_ADV_A]),
        .b_i    (ctrl_s[IDX_ADV_B]),
        .adv_o  (adv)
    );

    // Load takes priority over a detected advance in the same cycle.
    always_comb begin
        if (!ctrl_s[IDX_MODE]) begin
            op = OP_LOAD;
        end else if (adv) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
    end

    dcs_stages #(
        .STAGES (STAGES)
    ) u_stages (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .op_i    (op),
        .word_i  (word_i),
        .ser_i   (ctrl_s[IDX_SER]),
        .stage_o (stages)
    );

    assign tail_o   = stages[TOP];
    assign tail_n_o = ~stages[TOP];

    // R2: while loading, the output shows the last parallel bit one cycle on.
    assert_load_tail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_s[IDX_MODE] |=> (tail_o == $past(word_i[TOP])));

    // R8: a load with a coincident advance still yields the parallel word.
    assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_s[IDX_MODE] && adv) |=> (stages == $past(word_i)));

endmodule

// File: tb/dcs_shifter_bench.sv
module dcs_shifter_bench;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         a = 1'b0, b = 1'b0, md = 1'b1, sr = 1'b0;
    logic [W-1:0] wd = '0;
    logic         tail, tail_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the stages, driven only by input levels.
    logic [W-1:0] m_st = '0;

    always #4 clk = ~clk;

    dcs_shifter #(.STAGES(W), .SYNC_DEPTH(2)) u_dcs_shifter (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .adv_a_i  (a),
        .adv_b_i  (b),
        .mode_i   (md),
        .ser_i    (sr),
        .word_i   (wd),
        .tail_o   (tail),
        .tail_n_o (tail_n)
    );

    function automatic logic [W-1:0] next_model(logic [W-1:0] st, logic old_c, logic new_c,
                                                logic ld_n, logic s, logic [W-1:0] par);
        if (!ld_n) return par;
        if (new_c && !old_c) return {st[W-2:0], s};
        return st;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out(string tag);
        check(tag, tail, m_st[W-1]);
        check("R9", tail_n, ~tail);
    endtask

    // kind: 0 adv A, 1 adv B, 2 mode, 3 serial, 4 word
    task automatic apply(int kind, logic v, logic [W-1:0] nw);
        logic  oc, nc;
        string tag;
        @(negedge clk);
        oc = a | b;
        case (kind)
            0: a = v;
            1: b = v;
            2: md = v;
            3: sr = v;
            default: wd = nw;
        endcase
        nc = a | b;
        if (!md)                     tag = "R2";
        else if (nc && !oc)          tag = (kind == 0) ? "R4" : "R7";
        else if ((kind < 2) && v)    tag = "R5";
        else                         tag = "R6";
        m_st = next_model(m_st, oc, nc, md, sr, wd);
        repeat (4) @(negedge clk);
        check_out(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        logic [W-1:0] byte_v;
        void'($urandom(32'h5EED_0165));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", tail, 1'b0);
        check("R1", tail_n, 1'b1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", tail, 1'b0);

        // R2 / R3 / R4 / R7: load a byte, shift it out alternating inputs
        byte_v = 8'b1011_0010;
        apply(4, 1'b0, byte_v);
        apply(2, 1'b0, byte_v);
        check("R2", tail, byte_v[7]);
        apply(4, 1'b0, 8'b0100_1101);   // follow the word while loading
        check("R2", tail, 1'b0);
        apply(4, 1'b0, byte_v);
        apply(2, 1'b1, byte_v);
        for (int k = 0; k < 8; k++) begin
            apply(3, logic'(k[0]), wd);
            apply((k % 2 == 0) ? 0 : 1, 1'b1, wd);
            check("R3", tail, (k < 7) ? byte_v[6-k] : 1'b0);
            apply((k % 2 == 0) ? 0 : 1, 1'b0, wd);
        end

        // R5: hold A high, pulse B -> no shift
        apply(0, 1'b1, wd);
        apply(1, 1'b1, wd);
        apply(1, 1'b0, wd);
        apply(0, 1'b0, wd);

        // R10: latency of exactly three system edges
        apply(3, ~m_st[W-2], wd);
        @(negedge clk);
        a = 1'b1;
        m_st = {m_st[W-2:0], sr};
        repeat (2) @(negedge clk);
        check("R10", tail, ~m_st[W-1]);
        @(negedge clk);
        check("R10", tail, m_st[W-1]);
        apply(0, 1'b0, wd);

        // R8: load and advance edge arrive in the same cycle
        apply(4, 1'b0, 8'h7F);
        @(negedge clk);
        a = 1'b1;
        md = 1'b0;
        m_st = wd;
        repeat (4) @(negedge clk);
        check("R8", tail, 1'b0);
        apply(2, 1'b1, wd);
        apply(0, 1'b0, wd);
        apply(1, 1'b1, wd);          // one shift: 0x7F -> bit 6 = 1 at tail
        check("R8", tail, 1'b1);
        apply(1, 1'b0, wd);

        // Random walk, one input change at a time
        for (int n = 0; n < 400; n++) begin
            int unsigned k = $urandom_range(0, 9);
            if (k < 3)       apply(0, ~a, wd);
            else if (k < 6)  apply(1, ~b, wd);
            else if (k == 6) apply(2, ~md, wd);
            else if (k == 7) apply(3, ~sr, wd);
            else             apply(4, 1'b0, W'($urandom));
        end

        finish_run();
    end

endmodule